// File: doc/BRIEF.md
# Parallel Port Host Register Interface

This block is the host-facing register file of a PC-style parallel port. A simple synchronous host bus (address, write strobe, read strobe, byte-wide write data, registered byte-wide read data) reaches a lower window of eight byte offsets and an upper window that starts 400h above it. Behind these offsets sit the port data byte, a read-only status byte built from the peripheral's status lines, a control byte, an EPP address byte, four EPP data bytes and an extended control byte whose top three bits choose the port mode.

The block drives the byte and its output enable toward the connector, and drives the four control lines at connector polarity. It samples the five status lines coming back from the peripheral. An external EPP handshake engine, which is not part of this block, reports a timed-out transfer with a one-cycle pulse. The block latches that pulse as a sticky flag that the host clears by reading the status byte. The handshake engines, any FIFO and the bus bridge sit outside.

Top module: `ppt_host_regs`

## Requirements
- R1: Reads of offsets 400h, 401h, 403h, and of any address outside 000h–007h and 400h–403h, return 00h. Writes to them change no register and no output.
- R2: Read data appears on `bus_rdata` in the cycle after the clock edge that samples `bus_rd`. In a cycle that follows an edge with no read, `bus_rdata` is 00h.
- R3: After reset the mode is 000. The extended control byte (402h) reads 01h, the control byte (002h) reads 00h, status bits 2:0 read 111, and `pd_oe` is 1.
- R4: In mode 000 the data byte (000h) is driven on `pd_out` with `pd_oe` = 1, whatever the direction bit is. `pd_out` always carries the last byte written to 000h.
- R5: In any mode other than 000, `pd_oe` is the inverse of control bit 5 (direction). A 1 tri-states the data drivers.
- R6: A read of 000h returns the value present on `pd_in`, the data lines, not the stored byte.
- R7: The status byte (001h) is {not busy, ack_n, pe, select, err_n, 1, 1, bit0}, taken from `periph_sts_i` = {busy, ack_n, pe, select, err_n} (bit 4 down to bit 0). Writes to 001h are ignored.
- R8: Control bits 5:0 are writable and bits 7:6 read 0. Bit 0 is strobe, bit 1 auto-feed, bit 2 init, bit 3 select-in and bit 4 interrupt enable. `ctl_n_o` = {~bit3, bit2, ~bit1, ~bit0} (select-in, init, auto-feed and strobe at connector level), and `irq_en_o` = bit 4.
- R9: A write to 402h sets the mode from bits 7:5. Bits 4:0 always read 00001, and the values written to them are ignored.
- R10: Offsets 003h (EPP address) and 004h–007h (EPP data 1–4) are read/write only when the mode equals the EPP code (default 100). In other modes they read 00h, writes have no effect, and the stored values are kept.
- R11: A pulse on `epp_tmo_i` while in EPP mode sets the timeout flag. Status bit 0 reads the flag in EPP mode and reads 1 in every other mode. A pulse outside EPP mode is ignored.
- R12: A status read in EPP mode returns the flag and then clears it. If a timeout pulse arrives in the same cycle as that read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (11) | Host byte offset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| pd_in | input | 8 | Value present on the port data lines |
| pd_out | output | 8 | Data byte toward the connector |
| pd_oe | output | 1 | Data line output enable |
| ctl_n_o | output | 4 | Select-in, init, auto-feed, strobe at connector level |
| irq_en_o | output | 1 | Interrupt enable control bit |
| periph_sts_i | input | 5 | Busy, ack_n, pe, select, err_n from the peripheral |
| epp_tmo_i | input | 1 | Timeout pulse from the EPP handshake engine |

## Verification
The bench sweeps the direction bit across modes 000, 001, EPP and 111 while the far end holds a byte of its own. This shows whether the enable follows the mode, the direction bit, or both, and whether a data read returns the lines or the stored byte. Status reads use all-zero, all-one and alternating status patterns, so that the single inverted bit and any swapped positions stand out. The EPP bytes are written and read in a non-EPP mode, then in EPP mode, then again after leaving EPP mode, which separates gated access from lost storage. Timeout pulses arrive alone, together with a status read, and outside EPP mode, which separates the set, clear and same-cycle priority rules.

// File: rtl/ppt_pkg.sv
package ppt_pkg;

    localparam int BYTE_W      = 8;
    localparam int UPPER_OFS   = 'h400;
    localparam int EPP_BASE    = 3;
    localparam int EPP_IDX_W   = 3;
    localparam int LOWER_SPAN  = 8;

    localparam logic [2:0] MODE_COMPAT   = 3'b000;
    localparam logic [4:0] ECR_LOW_FIXED = 5'b00001;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PDR,
        SEL_DSR,
        SEL_DCR,
        SEL_EPP,
        SEL_ECR,
        SEL_RSVD
    } reg_sel_e;

    typedef struct packed {
        logic dir;
        logic irq_en;
        logic sel_in;
        logic init;
        logic auto_fd;
        logic strobe;
    } dcr_t;

    typedef struct packed {
        logic busy;
        logic ack_n;
        logic pe;
        logic slct;
        logic err_n;
    } periph_sts_t;

    function automatic logic [BYTE_W-1:0] pack_dsr(periph_sts_t s, logic bit0);
        return {~s.busy, s.ack_n, s.pe, s.slct, s.err_n, 1'b1, 1'b1, bit0};
    endfunction

    function automatic logic [3:0] ctl_lines(dcr_t d);
        return {~d.sel_in, d.init, ~d.auto_fd, ~d.strobe};
    endfunction

    function automatic logic [BYTE_W-1:0] pack_dcr(dcr_t d);
        return {2'b00, d};
    endfunction

endpackage

// File: rtl/ppt_addr_dec.sv
module ppt_addr_dec
    import ppt_pkg::*;
#(
    parameter int AW        = 11,
    parameter int EPP_SLOTS = 5
) (
    input  logic [AW-1:0]        addr,
    output reg_sel_e             sel,
    output logic [EPP_IDX_W-1:0] epp_idx
);

    localparam logic [AW-1:0] UPPER = AW'(UPPER_OFS);

    logic [2:0] rel;

    always_comb begin
        sel     = SEL_NONE;
        epp_idx = '0;
        rel     = addr[2:0] - 3'(EPP_BASE);
        if (addr[AW-1:3] == '0) begin
            case (addr[2:0])
                3'd0:    sel = SEL_PDR;
                3'd1:    sel = SEL_DSR;
                3'd2:    sel = SEL_DCR;
                default: begin
                    if (int'(rel) < EPP_SLOTS) begin
                        sel     = SEL_EPP;
                        epp_idx = rel;
                    end
                end
            endcase
        end else if (addr[AW-1:2] == UPPER[AW-1:2]) begin
            if (addr[1:0] == 2'd2) sel = SEL_ECR;
            else                   sel = SEL_RSVD;
        end
    end

endmodule

// File: rtl/ppt_ctrl_regs.sv
module ppt_ctrl_regs
    import ppt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_pdr,
    input  logic              wr_dcr,
    input  logic              wr_ecr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [2:0]        mode,
    output dcr_t              dcr,
    output logic [BYTE_W-1:0] pdr,
    output logic              pd_oe
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= MODE_COMPAT;
            dcr  <= '0;
            pdr  <= '0;
        end else begin
            if (wr_pdr) pdr  <= wdata;
            if (wr_dcr) dcr  <= dcr_t'(wdata[5:0]);
            if (wr_ecr) mode <= wdata[7:5];
        end
    end

    always_comb begin
        if (mode == MODE_COMPAT) pd_oe = 1'b1;
        else                     pd_oe = ~dcr.dir;
    end

endmodule

// File: rtl/ppt_epp_regs.sv
module ppt_epp_regs
    import ppt_pkg::*;
#(
    parameter int SLOTS = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [EPP_IDX_W-1:0] idx,
    input  logic [BYTE_W-1:0]    wdata,
    output logic [BYTE_W-1:0]    rdata
);

    logic [BYTE_W-1:0] slot_q [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)                                       slot_q[g] <= '0;
            else if (wr_en && idx == EPP_IDX_W'(g))        slot_q[g] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (idx == EPP_IDX_W'(i)) rdata = slot_q[i];
        end
    end

endmodule

// File: rtl/ppt_status.sv
module ppt_status
    import ppt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              epp_active,
    input  logic              rd_dsr,
    input  logic              tmo_pulse,
    input  periph_sts_t       sts,
    output logic [BYTE_W-1:0] dsr,
    output logic              tmo_flag
);

    always_ff @(posedge clk) begin
        if (rst)                          tmo_flag <= 1'b0;
        else if (epp_active && tmo_pulse) tmo_flag <= 1'b1;
        else if (epp_active && rd_dsr)    tmo_flag <= 1'b0;
    end

    assign dsr = pack_dsr(sts, epp_active ? tmo_flag : 1'b1);

endmodule

// File: rtl/ppt_host_regs.sv
module ppt_host_regs
    import ppt_pkg::*;
#(
    parameter int         AW            = 11,
    parameter int         EPP_DATA_REGS = 4,
    parameter logic [2:0] EPP_MODE      = 3'b100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic [7:0]    pd_in,
    output logic [7:0]    pd_out,
    output logic          pd_oe,
    output logic [3:0]    ctl_n_o,
    output logic          irq_en_o,
    input  logic [4:0]    periph_sts_i,
    input  logic          epp_tmo_i
);

    localparam int EPP_SLOTS = 1 + EPP_DATA_REGS;

    reg_sel_e             sel;
    logic [EPP_IDX_W-1:0] epp_idx;
    logic [2:0]           mode_q;
    dcr_t                 dcr_q;
    logic [BYTE_W-1:0]    pdr_q;
    logic [BYTE_W-1:0]    epp_rdata;
    logic [BYTE_W-1:0]    dsr_byte;
    logic                 tmo_flag;
    logic                 epp_active;
    logic                 dcr_dir;
    logic [BYTE_W-1:0]    rd_mux;
    logic [BYTE_W-1:0]    rdata_q;

    assign epp_active = (mode_q == EPP_MODE);
    assign dcr_dir    = dcr_q.dir;

    ppt_addr_dec #(.AW(AW), .EPP_SLOTS(EPP_SLOTS)) u_dec (
        .addr    (bus_addr),
        .sel     (sel),
        .epp_idx (epp_idx)
    );

    ppt_ctrl_regs u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_pdr (bus_wr && sel == SEL_PDR),
        .wr_dcr (bus_wr && sel == SEL_DCR),
        .wr_ecr (bus_wr && sel == SEL_ECR),
        .wdata  (bus_wdata),
        .mode   (mode_q),
        .dcr    (dcr_q),
        .pdr    (pdr_q),
        .pd_oe  (pd_oe)
    );

    ppt_epp_regs #(.SLOTS(EPP_SLOTS)) u_epp (
        .clk   (clk),
        .rst   (rst),
        .wr_en (bus_wr && sel == SEL_EPP && epp_active),
        .idx   (epp_idx),
        .wdata (bus_wdata),
        .rdata (epp_rdata)
    );

    ppt_status u_sts (
        .clk        (clk),
        .rst        (rst),
        .epp_active (epp_active),
        .rd_dsr     (bus_rd && sel == SEL_DSR),
        .tmo_pulse  (epp_tmo_i),
        .sts        (periph_sts_t'(periph_sts_i)),
        .dsr        (dsr_byte),
        .tmo_flag   (tmo_flag)
    );

    always_comb begin
        case (sel)
            SEL_PDR: rd_mux = pd_in;
            SEL_DSR: rd_mux = dsr_byte;
            SEL_DCR: rd_mux = pack_dcr(dcr_q);
            SEL_EPP: rd_mux = epp_active ? epp_rdata : '0;
            SEL_ECR: rd_mux = {mode_q, ECR_LOW_FIXED};
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_mux;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign pd_out    = pdr_q;
    assign ctl_n_o   = ctl_lines(dcr_q);
    assign irq_en_o  = dcr_q.irq_en;

endmodule

// File: rtl/ppt_host_regs_chk.sv
module ppt_host_regs_chk #(
    parameter int         AW       = 11,
    parameter logic [2:0] EPP_MODE = 3'b100
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic          bus_rd,
    input logic [7:0]    bus_rdata,
    input logic          epp_tmo_i,
    input logic [2:0]    mode,
    input logic          tmo_flag,
    input logic          pd_oe,
    input logic          dir
);

    localparam logic [AW-1:0] A_DSR = AW'('h001);
    localparam logic [AW-1:0] A_R0  = AW'('h400);
    localparam logic [AW-1:0] A_R1  = AW'('h401);
    localparam logic [AW-1:0] A_ECR = AW'('h402);
    localparam logic [AW-1:0] A_R3  = AW'('h403);

    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd && (bus_addr == A_R0 || bus_addr == A_R1 || bus_addr == A_R3))
        |-> bus_rdata == 8'h00);

    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_rd) |-> bus_rdata == 8'h00);

    p_compat_drive_r4: assert property (@(posedge clk) disable iff (rst)
        mode == 3'b000 |-> pd_oe);

    p_dir_tristate_r5: assert property (@(posedge clk) disable iff (rst)
        (mode != 3'b000 && dir) |-> !pd_oe);

    p_fixed_ones_r7: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd && bus_addr == A_DSR) |-> bus_rdata[2:1] == 2'b11);

    p_ecr_low_r9: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd && bus_addr == A_ECR) |-> bus_rdata[4:0] == 5'b00001);

    p_tmo_set_r11: assert property (@(posedge clk) disable iff (rst)
        $past(epp_tmo_i && mode == EPP_MODE) |-> tmo_flag);

    p_tmo_clear_r12: assert property (@(posedge clk) disable iff (rst)
        $past(bus_rd && bus_addr == A_DSR && mode == EPP_MODE && !epp_tmo_i) |-> !tmo_flag);

endmodule

bind ppt_host_regs ppt_host_regs_chk #(.AW(AW), .EPP_MODE(EPP_MODE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .epp_tmo_i (epp_tmo_i),
    .mode      (mode_q),
    .tmo_flag  (tmo_flag),
    .pd_oe     (pd_oe),
    .dir       (dcr_dir)
);

// File: tb/ppt_host_regs_tb.sv
module ppt_host_regs_tb;

    localparam logic [2:0] EPP_MODE = 3'b100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pd_in;
    logic [7:0]  pd_out;
    logic        pd_oe;
    logic [3:0]  ctl_n_o;
    logic        irq_en_o;
    logic [4:0]  periph_sts_i = '0;
    logic        epp_tmo_i = 1'b0;
    logic [7:0]  ext_data = 8'h00;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    always #4 clk = ~clk;

    assign pd_in = pd_oe ? pd_out : ext_data;

    ppt_host_regs #(.EPP_MODE(EPP_MODE)) u_dut (
        .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
        .pd_in, .pd_out, .pd_oe, .ctl_n_o, .irq_en_o, .periph_sts_i, .epp_tmo_i
    );

    // behavioural reference state
    logic [2:0] m_mode;
    logic [5:0] m_dcr;
    logic [7:0] m_pdr;
    logic [7:0] m_epp [5];
    bit         m_tmo;
    logic [7:0] m_rdata;
    string      m_tag;
    logic [7:0] m_lines;

    function automatic bit m_oe(logic [2:0] md, logic [5:0] d);
        return (md == 3'b000) ? 1'b1 : ~d[5];
    endfunction

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_mode = 3'b000; m_dcr = '0; m_pdr = '0; m_tmo = 0;
            m_rdata = '0; m_tag = "R2";
            for (int i = 0; i < 5; i++) m_epp[i] = '0;
        end else begin
            m_lines = m_oe(m_mode, m_dcr) ? m_pdr : ext_data;
            m_rdata = 8'h00;
            m_tag   = "R2";
            if (bus_rd) begin
                m_tag = "R1";
                if (bus_addr == 11'h000) begin
                    m_rdata = m_lines; m_tag = "R6";
                end else if (bus_addr == 11'h001) begin
                    m_rdata = {~periph_sts_i[4], periph_sts_i[3:0], 2'b11,
                               (m_mode == EPP_MODE) ? m_tmo : 1'b1};
                    if (m_mode != EPP_MODE) m_tag = "R7";
                    else if (m_tmo)         m_tag = "R11";
                    else                    m_tag = "R12";
                end else if (bus_addr == 11'h002) begin
                    m_rdata = {2'b00, m_dcr}; m_tag = "R8";
                end else if (bus_addr >= 11'h003 && bus_addr <= 11'h007) begin
                    m_rdata = (m_mode == EPP_MODE) ? m_epp[bus_addr - 11'h003] : 8'h00;
                    m_tag = "R10";
                end else if (bus_addr == 11'h402) begin
                    m_rdata = {m_mode, 5'b00001}; m_tag = "R9";
                end
            end
            if (bus_rd && bus_addr == 11'h001 && m_mode == EPP_MODE) m_tmo = 0;
            if (epp_tmo_i && m_mode == EPP_MODE) m_tmo = 1;
            if (bus_wr) begin
                if (bus_addr == 11'h000) m_pdr = bus_wdata;
                else if (bus_addr == 11'h002) m_dcr = bus_wdata[5:0];
                else if (bus_addr == 11'h402) m_mode = bus_wdata[7:5];
                else if (bus_addr >= 11'h003 && bus_addr <= 11'h007 && m_mode == EPP_MODE)
                    m_epp[bus_addr - 11'h003] = bus_wdata;
            end
        end
    end

    // compare on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk(m_tag, int'(bus_rdata), int'(m_rdata));
            chk((m_mode == 3'b000) ? "R4" : "R5", int'(pd_oe), int'(m_oe(m_mode, m_dcr)));
            chk("R4", int'(pd_out), int'(m_pdr));
            chk("R8", int'({irq_en_o, ctl_n_o}),
                int'({m_dcr[4], ~m_dcr[3], m_dcr[2], ~m_dcr[1], ~m_dcr[0]}));
        end
    end

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rd_pulse(input logic [10:0] a);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1; epp_tmo_i = 1'b1;
        @(negedge clk); bus_rd = 1'b0; epp_tmo_i = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); epp_tmo_i = 1'b1;
        @(negedge clk); epp_tmo_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R3", int'(pd_oe), 1);
        rd(11'h402); chk("R3", int'(bus_rdata), 'h01);
        rd(11'h002); chk("R3", int'(bus_rdata), 'h00);
        rd(11'h001); chk("R3", int'(bus_rdata[2:0]), 'h7);

        // R1: reserved and unmapped offsets
        rd(11'h400); rd(11'h401); rd(11'h403); rd(11'h008); rd(11'h7FF);
        wr(11'h400, 8'hFF); wr(11'h403, 8'hFF); wr(11'h010, 8'h5A);
        rd(11'h400); rd(11'h402); rd(11'h002);

        // R8: control byte and connector lines
        wr(11'h002, 8'h3F); rd(11'h002);
        wr(11'h002, 8'hC5); rd(11'h002);
        wr(11'h002, 8'h0A); rd(11'h002);

        // R4 / R6: compatibility mode drives regardless of direction
        wr(11'h000, 8'hA5);
        wr(11'h002, 8'h20);
        ext_data = 8'h3C;
        rd(11'h000); chk("R6", int'(bus_rdata), 'hA5);

        // R5 / R6: other mode, direction decides
        wr(11'h402, 8'h20);
        rd(11'h000); chk("R6", int'(bus_rdata), 'h3C);
        wr(11'h002, 8'h00);
        rd(11'h000); chk("R6", int'(bus_rdata), 'hA5);

        // R7: status patterns, write ignored
        periph_sts_i = 5'b00000; rd(11'h001); chk("R7", int'(bus_rdata), 'h87);
        periph_sts_i = 5'b11111; rd(11'h001);
        periph_sts_i = 5'b10101; rd(11'h001);
        wr(11'h001, 8'h00); rd(11'h001);

        // R10: EPP bytes gated outside EPP mode
        for (int i = 0; i < 5; i++) wr(11'(3 + i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 5; i++) rd(11'(3 + i));
        wr(11'h402, 8'h80);
        for (int i = 0; i < 5; i++) rd(11'(3 + i));
        for (int i = 0; i < 5; i++) wr(11'(3 + i), 8'(8'hC0 + i));
        for (int i = 0; i < 5; i++) rd(11'(3 + i));
        rd(11'h004); chk("R10", int'(bus_rdata), 'hC1);

        // R11 / R12: timeout flag
        rd(11'h001); chk("R11", int'(bus_rdata[0]), 0);
        pulse();
        rd(11'h001); chk("R11", int'(bus_rdata[0]), 1);
        rd(11'h001); chk("R12", int'(bus_rdata[0]), 0);
        pulse();
        rd_pulse(11'h001);
        rd(11'h001); chk("R12", int'(bus_rdata[0]), 1);
        rd(11'h001); chk("R12", int'(bus_rdata[0]), 0);

        // R11: pulse outside EPP mode ignored; EPP bytes kept
        wr(11'h402, 8'h00);
        pulse();
        rd(11'h001); chk("R11", int'(bus_rdata[0]), 1);
        rd(11'h005);
        wr(11'h402, 8'h80);
        rd(11'h001); chk("R11", int'(bus_rdata[0]), 0);
        rd(11'h005); chk("R10", int'(bus_rdata), 'hC2);

        // R9: low bits of extended control fixed
        wr(11'h402, 8'hFF); rd(11'h402); chk("R9", int'(bus_rdata), 'hE1);
        wr(11'h002, 8'h20); rd(11'h000);
        wr(11'h002, 8'h00); rd(11'h000);

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule